// File: doc/BRIEF.md
# Hardware Standby Power-State Controller

This block sits in the always-on clock domain of a chip and decides its power state. It follows run, sleep, software standby, post-interrupt oscillator settling, CPU resume, hardware standby and oscillator restart. Its outputs are the main clock gate, the oscillator enable, a timer-unit halt, a mask that blocks interrupts and manual resets, an enable for the always-on real-time-clock domain, and a power-on reset request for the CPU.

Two active-low pins control the deepest state. One is a standby request pin and the other is a power-on reset pin. Both pass through synchronizers before the state machine uses them. Pulling the standby pin low always ends in hardware standby, but the route there depends on the current state. In run and in software standby the block goes there directly. In sleep, and during settling after an interrupt wake, the CPU is first allowed to restart. Hardware standby is never left on an interrupt. The only way out is a handshake on the two pins: the standby pin rises while the reset pin is low, the oscillator restarts, and a settled rising edge on the reset pin produces one power-on reset pulse.

Top module: `hw_standby_ctrl`

## Requirements
- R1: After `rst_n` is released the block is in run: `clk_gate_en`=1, `osc_en`=1, `tmu_halt`=0, `irq_mask`=0, `por_req`=0, `settle_err`=0.
- R2: `aon_en` stays 1 in every state.
- R3: In hardware standby, oscillator restart and the reset pulse cycle, `tmu_halt`=1, `irq_mask`=1 and `clk_gate_en`=0. Pulses on `irq` and `mrst_req` there do not change any output.
- R4: Each pin passes through SYNC_STAGES flops. In run, a low standby pin drops `clk_gate_en` in the first cycle after the synchronizer delivers it. On the next edge the block is in hardware standby (`tmu_halt`=1, `osc_en`=0).
- R5: `sleep_req` with `stby_sel`=1 enters software standby (`clk_gate_en`=0, `osc_en`=0, `tmu_halt`=0). A low standby pin there leads to hardware standby without `clk_gate_en` ever rising.
- R6: `irq` or `mrst_req` in software standby starts settling (`osc_en`=1, `clk_gate_en`=0) until `settle_done`. The clock then runs until `cpu_restarted`. At that point the block goes to hardware standby if the standby pin is low, and to run otherwise.
- R7: `sleep_req` with `stby_sel`=0 enters sleep (`clk_gate_en`=0, `osc_en`=1). `irq` or `mrst_req` returns it to run. A low standby pin turns the clock back on until `cpu_restarted`, and then the block goes to hardware standby.
- R8: Hardware standby is left only when the synchronized standby pin is high while the reset pin is low. The block then raises `osc_en` with the clock still gated. A standby pin rising while the reset pin is high leaves the block in hardware standby.
- R9: A synchronized rising edge of the reset pin during oscillator restart, with `settle_done`=1, gives `por_req`=1 for exactly one cycle. The block is in run on the next cycle with all masks cleared.
- R10: A reset-pin rising edge during oscillator restart with `settle_done`=0 is ignored: no `por_req`, and the state is unchanged. It also sets `settle_err`, which stays 1 until `rst_n`.
- R11: A low standby pin during oscillator restart returns the block to hardware standby (`osc_en`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| stby_pin_n | input | 1 | Active-low hardware standby request pin (asynchronous) |
| por_pin_n | input | 1 | Active-low power-on reset pin (asynchronous) |
| sleep_req | input | 1 | Sleep-instruction strobe |
| stby_sel | input | 1 | With sleep_req: 1 selects software standby, 0 selects sleep |
| irq | input | 1 | Interrupt request |
| mrst_req | input | 1 | Manual reset request |
| cpu_restarted | input | 1 | CPU has resumed execution |
| settle_done | input | 1 | Oscillator-stable counter has expired |
| clk_gate_en | output | 1 | Main clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| tmu_halt | output | 1 | Timer unit halt |
| irq_mask | output | 1 | Blocks interrupts and manual resets |
| aon_en | output | 1 | Always-on (RTC) domain enable |
| por_req | output | 1 | One-cycle power-on reset request to the CPU |
| settle_err | output | 1 | Sticky: reset-pin edge came before settling |

## Verification
The bench builds the block with SYNC_STAGES at its default of 2. Its reference model therefore expects each pin change to reach the outputs exactly two edges later. That fixed latency lets the bench check the one-cycle clock-gate drop in run and the single-cycle reset pulse at exact cycles. It also makes it possible to place a reset-pin edge deliberately before or after `settle_done`, so both the honoured edge and the rejected edge are exercised.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_SWSTBY  = 3'd2,
    ST_SETTLE  = 3'd3,
    ST_RESUME  = 3'd4,
    ST_HWSTBY  = 3'd5,
    ST_OSCUP   = 3'd6,
    ST_PORPLS  = 3'd7
  } hsb_state_e;

  typedef struct packed {
    logic clk_on;
    logic osc_on;
    logic tmu_halt;
    logic mask;
    logic aon_on;
    logic por_pulse;
  } hsb_out_t;

  function automatic hsb_out_t state_outputs(hsb_state_e s);
    hsb_out_t o;
    o = '{clk_on: 1'b0, osc_on: 1'b1, tmu_halt: 1'b0, mask: 1'b0,
          aon_on: 1'b1, por_pulse: 1'b0};
    unique case (s)
      ST_RUN, ST_RESUME: o.clk_on = 1'b1;
      ST_SLEEP, ST_SETTLE: o.clk_on = 1'b0;
      ST_SWSTBY: o.osc_on = 1'b0;
      ST_HWSTBY: begin
        o.osc_on   = 1'b0;
        o.tmu_halt = 1'b1;
        o.mask     = 1'b1;
      end
      ST_OSCUP: begin
        o.tmu_halt = 1'b1;
        o.mask     = 1'b1;
      end
      ST_PORPLS: begin
        o.tmu_halt  = 1'b1;
        o.mask      = 1'b1;
        o.por_pulse = 1'b1;
      end
      default: o = o;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= RST_VAL;
    else        stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= RST_VAL;
      else        stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/hsb_fsm.sv
module hsb_fsm
  import hsb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stby_ok,
  input  logic por_ok,
  input  logic sleep_req,
  input  logic stby_sel,
  input  logic irq,
  input  logic mrst_req,
  input  logic cpu_restarted,
  input  logic settle_done,
  output logic clk_gate_en,
  output logic osc_en,
  output logic tmu_halt,
  output logic irq_mask,
  output logic aon_en,
  output logic por_req,
  output logic settle_err
);
  hsb_state_e state, state_nx;
  logic       por_q;
  logic       por_rise;
  logic       early_rise;
  logic       wake_evt;
  hsb_out_t   outs;

  assign por_rise   = por_ok & ~por_q;
  assign early_rise = (state == ST_OSCUP) & stby_ok & por_rise & ~settle_done;
  assign wake_evt   = irq | mrst_req;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:
        if (!stby_ok)       state_nx = ST_HWSTBY;
        else if (sleep_req) state_nx = stby_sel ? ST_SWSTBY : ST_SLEEP;
      ST_SLEEP:
        if (!stby_ok)       state_nx = ST_RESUME;
        else if (wake_evt)  state_nx = ST_RUN;
      ST_SWSTBY:
        if (!stby_ok)       state_nx = ST_HWSTBY;
        else if (wake_evt)  state_nx = ST_SETTLE;
      ST_SETTLE:
        if (settle_done)    state_nx = ST_RESUME;
      ST_RESUME:
        if (cpu_restarted)  state_nx = stby_ok ? ST_RUN : ST_HWSTBY;
      ST_HWSTBY:
        if (stby_ok && !por_ok) state_nx = ST_OSCUP;
      ST_OSCUP:
        if (!stby_ok)                      state_nx = ST_HWSTBY;
        else if (por_rise && settle_done)  state_nx = ST_PORPLS;
      ST_PORPLS:            state_nx = ST_RUN;
      default:              state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      por_q      <= 1'b1;
      settle_err <= 1'b0;
    end else begin
      state <= state_nx;
      por_q <= por_ok;
      if (early_rise) settle_err <= 1'b1;
    end
  end

  assign outs        = state_outputs(state);
  assign clk_gate_en = outs.clk_on & ((state != ST_RUN) | stby_ok);
  assign osc_en      = outs.osc_on;
  assign tmu_halt    = outs.tmu_halt;
  assign irq_mask    = outs.mask;
  assign aon_en      = outs.aon_on;
  assign por_req     = outs.por_pulse;

  a_r3_no_wake_from_hw: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HWSTBY && wake_evt && !stby_ok) |=> (state == ST_HWSTBY));

  a_r4_gate_drop_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !stby_ok) |=> (tmu_halt && !clk_gate_en));

  a_r8_exit_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HWSTBY && !(stby_ok && !por_ok)) |=> (state == ST_HWSTBY));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> (!por_req && clk_gate_en == stby_ok && !irq_mask));

  a_r10_err_on_early: assert property (@(posedge clk) disable iff (!rst_n)
    early_rise |=> (settle_err && !por_req));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    settle_err |=> settle_err);

endmodule

// File: rtl/hw_standby_ctrl.sv
module hw_standby_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_pin_n,
  input  logic por_pin_n,
  input  logic sleep_req,
  input  logic stby_sel,
  input  logic irq,
  input  logic mrst_req,
  input  logic cpu_restarted,
  input  logic settle_done,
  output logic clk_gate_en,
  output logic osc_en,
  output logic tmu_halt,
  output logic irq_mask,
  output logic aon_en,
  output logic por_req,
  output logic settle_err
);
  localparam int PINS = 2;
  logic [PINS-1:0] pins_raw, pins_sync;

  assign pins_raw = {por_pin_n, stby_pin_n};

  hsb_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL({PINS{1'b1}})) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins_raw),
    .q    (pins_sync)
  );

  hsb_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .stby_ok      (pins_sync[0]),
    .por_ok       (pins_sync[1]),
    .sleep_req    (sleep_req),
    .stby_sel     (stby_sel),
    .irq          (irq),
    .mrst_req     (mrst_req),
    .cpu_restarted(cpu_restarted),
    .settle_done  (settle_done),
    .clk_gate_en  (clk_gate_en),
    .osc_en       (osc_en),
    .tmu_halt     (tmu_halt),
    .irq_mask     (irq_mask),
    .aon_en       (aon_en),
    .por_req      (por_req),
    .settle_err   (settle_err)
  );
endmodule

// File: tb/sim_hw_standby_ctrl.sv
module sim_hw_standby_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby_pin_n = 1'b1, por_pin_n = 1'b1;
  logic sleep_req = 1'b0, stby_sel = 1'b0, irq = 1'b0, mrst_req = 1'b0;
  logic cpu_restarted = 1'b0, settle_done = 1'b0;
  logic clk_gate_en, osc_en, tmu_halt, irq_mask, aon_en, por_req, settle_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_standby_ctrl #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .stby_pin_n(stby_pin_n), .por_pin_n(por_pin_n),
    .sleep_req(sleep_req), .stby_sel(stby_sel), .irq(irq), .mrst_req(mrst_req),
    .cpu_restarted(cpu_restarted), .settle_done(settle_done),
    .clk_gate_en(clk_gate_en), .osc_en(osc_en), .tmu_halt(tmu_halt),
    .irq_mask(irq_mask), .aon_en(aon_en), .por_req(por_req), .settle_err(settle_err)
  );

  // Reference model: mode names as strings, pin delay lines as queues.
  string mode;
  bit    stby_q[$];
  bit    por_q[$];
  bit    por_prev;
  bit    err_m;

  function automatic bit stby_seen(); return stby_q[0]; endfunction
  function automatic bit por_seen();  return por_q[0];  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = "run"; err_m = 0; por_prev = 1;
      stby_q = {}; por_q = {};
      for (int i = 0; i < SYNC; i++) begin stby_q.push_back(1); por_q.push_back(1); end
    end else begin
      bit s, p, rise;
      string nx;
      s = stby_seen(); p = por_seen();
      rise = p && !por_prev;
      nx = mode;
      if (mode == "run") begin
        if (!s) nx = "hw"; else if (sleep_req) nx = stby_sel ? "sw" : "sleep";
      end else if (mode == "sleep") begin
        if (!s) nx = "resume"; else if (irq || mrst_req) nx = "run";
      end else if (mode == "sw") begin
        if (!s) nx = "hw"; else if (irq || mrst_req) nx = "settle";
      end else if (mode == "settle") begin
        if (settle_done) nx = "resume";
      end else if (mode == "resume") begin
        if (cpu_restarted) nx = s ? "run" : "hw";
      end else if (mode == "hw") begin
        if (s && !p) nx = "oscup";
      end else if (mode == "oscup") begin
        if (!s) nx = "hw";
        else if (rise && settle_done) nx = "pulse";
        else if (rise) err_m = 1;
      end else nx = "run";
      mode = nx;
      por_prev = p;
      void'(stby_q.pop_front()); stby_q.push_back(stby_pin_n);
      void'(por_q.pop_front());  por_q.push_back(por_pin_n);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (mode %s, t=%0t)", req, what, act, exp, mode, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) if (rst_n && !done) begin
    bit e_clk, e_osc, e_halt;
    e_clk  = (mode == "run") ? stby_seen() : (mode == "resume");
    e_osc  = !(mode == "sw" || mode == "hw");
    e_halt = (mode == "hw" || mode == "oscup" || mode == "pulse");
    check("R4", "clk_gate_en", clk_gate_en, e_clk);
    check("R8", "osc_en", osc_en, e_osc);
    check("R3", "tmu_halt", tmu_halt, e_halt);
    check("R3", "irq_mask", irq_mask, e_halt);
    check("R2", "aon_en", aon_en, 1);
    check("R9", "por_req", por_req, mode == "pulse");
    check("R10", "settle_err", settle_err, err_m);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_irq();
    irq = 1; step(1); irq = 0;
  endtask

  // From hardware standby, run the exit handshake back to run.
  task automatic exit_hw();
    por_pin_n = 0; step(1);
    stby_pin_n = 1; step(SYNC + 2);
    check("R8", "osc_en in restart", osc_en, 1);
    check("R8", "clk_gate_en in restart", clk_gate_en, 0);
    settle_done = 1;
    por_pin_n = 1; step(SYNC + 1);
    check("R9", "por_req pulse", por_req, 1);
    step(1);
    check("R9", "por_req single", por_req, 0);
    check("R9", "irq_mask cleared", irq_mask, 0);
    settle_done = 0;
    step(1);
  endtask

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    check("R1", "clk_gate_en", clk_gate_en, 1);
    check("R1", "osc_en", osc_en, 1);
    check("R1", "tmu_halt", tmu_halt, 0);
    check("R1", "irq_mask", irq_mask, 0);
    check("R1", "por_req", por_req, 0);
    check("R1", "settle_err", settle_err, 0);
    step(3);

    // R4: run -> hardware standby
    stby_pin_n = 0; step(SYNC);
    check("R4", "clk dropped", clk_gate_en, 0);
    check("R4", "not yet halted", tmu_halt, 0);
    step(1);
    check("R4", "halted next edge", tmu_halt, 1);
    check("R4", "osc off", osc_en, 0);

    // R3: wake requests ignored
    pulse_irq(); mrst_req = 1; step(1); mrst_req = 0; step(2);
    check("R3", "still halted", tmu_halt, 1);
    check("R3", "clock still off", clk_gate_en, 0);

    // R8: standby pin high with reset pin high keeps hardware standby
    stby_pin_n = 1; step(SYNC + 3);
    check("R8", "no exit with por high", osc_en, 0);
    stby_pin_n = 0; step(SYNC + 1);

    // R10: early reset-pin edge
    por_pin_n = 0; step(1);
    stby_pin_n = 1; step(SYNC + 2);
    por_pin_n = 1; step(SYNC + 2);
    check("R10", "settle_err set", settle_err, 1);
    check("R10", "still restarting", tmu_halt, 1);
    // R11: standby pin low again in restart
    stby_pin_n = 0; step(SYNC + 1);
    check("R11", "osc off again", osc_en, 0);
    exit_hw();
    check("R10", "settle_err sticky", settle_err, 1);

    // R7: sleep and interrupt wake
    stby_sel = 0; sleep_req = 1; step(1); sleep_req = 0;
    check("R7", "sleep clk off", clk_gate_en, 0);
    check("R7", "sleep osc on", osc_en, 1);
    step(2); pulse_irq();
    check("R7", "irq back to run", clk_gate_en, 1);
    // R7: standby pin during sleep
    sleep_req = 1; step(1); sleep_req = 0; step(1);
    stby_pin_n = 0; step(SYNC + 1);
    check("R7", "clock resumes", clk_gate_en, 1);
    check("R7", "not halted", tmu_halt, 0);
    step(2);
    cpu_restarted = 1; step(1); cpu_restarted = 0;
    check("R7", "then hardware standby", tmu_halt, 1);
    exit_hw();

    // R5: software standby then standby pin
    stby_sel = 1; sleep_req = 1; step(1); sleep_req = 0;
    check("R5", "sw osc off", osc_en, 0);
    check("R5", "sw clk off", clk_gate_en, 0);
    stby_pin_n = 0;
    for (int i = 0; i < SYNC + 2; i++) begin
      step(1);
      check("R5", "clk never rises", clk_gate_en, 0);
    end
    check("R5", "direct hardware standby", tmu_halt, 1);
    exit_hw();

    // R6: interrupt wake, standby pin during settling
    sleep_req = 1; step(1); sleep_req = 0; step(1);
    pulse_irq();
    check("R6", "settle osc on", osc_en, 1);
    check("R6", "settle clk off", clk_gate_en, 0);
    stby_pin_n = 0; step(SYNC + 2);
    check("R6", "waits for settle", tmu_halt, 0);
    settle_done = 1; step(1); settle_done = 0;
    check("R6", "clock on to restart cpu", clk_gate_en, 1);
    step(2);
    cpu_restarted = 1; step(1); cpu_restarted = 0;
    check("R6", "then hardware standby", tmu_halt, 1);
    exit_hw();

    // R6: interrupt wake with standby pin high returns to run
    sleep_req = 1; step(1); sleep_req = 0; step(1);
    mrst_req = 1; step(1); mrst_req = 0; step(3);
    settle_done = 1; step(1); settle_done = 0;
    cpu_restarted = 1; step(1); cpu_restarted = 0;
    check("R6", "back in run", clk_gate_en, 1);
    check("R6", "not halted", tmu_halt, 0);
    step(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule